// File: doc/BRIEF.md
# Coherent Position Snapshot Reader

This block sits between a free-running position counter and an 8-bit processor bus. It keeps a registered snapshot of the count. A bus master reads that snapshot as two bytes, one after the other, through a single byte-wide port. The tri-state port is modelled as a byte of data plus a drive-enable flag.

A processor that reads a wide counter one byte at a time can get its high byte from one count and its low byte from a later one. To avoid this, the block samples its active-low enable and its byte select on every falling clock edge. From the first sampled enable it freezes the snapshot. It releases the snapshot only after the low byte has been read and the enable has been withdrawn. The counter itself lives elsewhere and arrives on an input. The counter width is a parameter, so both 12-bit and 16-bit counters are served over the same two-byte port.

Top module: `pos_latch_bytebus`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, the snapshot is zero and the freeze state is clear. A read during or right after reset returns 0x00 for both bytes.
- R2: While the freeze state is clear, every rising clock edge copies `count_i` into the snapshot. The last count presented before that edge is the value read afterwards.
- R3: With `byte_sel` = 0 the port carries snapshot bits 15..8 (the high byte). With `byte_sel` = 1 it carries bits 7..0 (the low byte). The selection is combinational, with no clock between select and data.
- R4: With `CNT_W` = 12, bits 7..4 of the high byte always read as zero, and bits 3..0 carry count bits 11..8.
- R5: While `oe_n` is high, `data_oe` is 0 and `data_o` is 0x00, whatever the value of `byte_sel`.
- R6: A falling clock edge that samples `oe_n` low sets the freeze state. While it is set, the snapshot keeps its value, so count changes made in the middle of a two-byte read do not appear in either byte.
- R7: The freeze state clears only on a falling edge that samples `oe_n` high, and only if a falling edge during the freeze had sampled `oe_n` low with `byte_sel` = 1. A read of the high byte alone leaves the snapshot frozen.
- R8: After the freeze state clears, the snapshot takes the current count on the very next rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the snapshot updates on the rising edge and the bus controls are sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset of the snapshot and the freeze state |
| count_i | input | CNT_W | Current value of the external position counter |
| oe_n | input | 1 | Active-low bus read enable |
| byte_sel | input | 1 | Byte choice: 0 selects the high byte, 1 selects the low byte |
| data_o | output | 8 | Selected snapshot byte, or 0x00 while the port is not enabled |
| data_oe | output | 1 | High while the port would drive the bus |

## Verification
The assertions rely on `oe_n` and `byte_sel` being stable around each falling clock edge. They also rely on `count_i` being stable around each rising edge, since the freeze logic and the snapshot capture are both judged at the sampling edge. The stimulus changes every input two nanoseconds after a rising edge, so each input has settled well before both the falling edge and the next rising edge. Reads follow the normal order: enable with the high byte, switch to the low byte, then withdraw the enable. The exceptions are a deliberately abandoned high-byte-only read and one enable placed in the half cycle just before the snapshot reload.

// File: rtl/pl_pkg.sv
package pl_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NBYTES = 2;

   typedef struct packed {
      logic hold;      // snapshot frozen
      logic low_done;  // low byte has been read during this freeze
   } inhibit_t;
endpackage

// File: rtl/pl_inhibit_ctrl.sv
module pl_inhibit_ctrl
   import pl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     oe_n,
   input  logic     byte_sel,
   output inhibit_t st
);
   // Bus controls are judged on the falling edge, half a cycle ahead of capture.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else if (!oe_n) begin
         st.hold     <= 1'b1;
         st.low_done <= st.low_done | byte_sel;
      end else if (st.hold && st.low_done) begin
         st <= '0;
      end
   end
endmodule

// File: rtl/pl_snapshot_reg.sv
module pl_snapshot_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     snap <= '0;
      else if (!hold) snap <= cnt;
   end
endmodule

// File: rtl/pl_byte_mux.sv
module pl_byte_mux
   import pl_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic              oe_n,
   input  logic              byte_sel,
   input  logic [W-1:0]      snap,
   output logic [BYTE_W-1:0] data_o,
   output logic              data_oe
);
   localparam int unsigned FULL_W = NBYTES * BYTE_W;
   localparam int unsigned PAD_W  = FULL_W - W;

   logic [FULL_W-1:0] wide;

   generate
      if (PAD_W == 0) begin : g_exact
         assign wide = snap;
      end else begin : g_pad
         assign wide = {{PAD_W{1'b0}}, snap};
      end
   endgenerate

   logic [BYTE_W-1:0] picked;
   always_comb begin
      picked  = byte_sel ? wide[BYTE_W-1:0] : wide[FULL_W-1:BYTE_W];
      data_oe = !oe_n;
      data_o  = data_oe ? picked : '0;
   end
endmodule

// File: rtl/pos_latch_bytebus.sv
module pos_latch_bytebus
   import pl_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             oe_n,
   input  logic             byte_sel,
   output logic [7:0]       data_o,
   output logic             data_oe
);
   generate
      if (CNT_W <= BYTE_W || CNT_W > NBYTES * BYTE_W) begin : g_bad_width
         $error("pos_latch_bytebus: CNT_W must lie between 9 and 16");
      end
   endgenerate

   inhibit_t         inh_st;
   logic             hold_w;
   logic             low_w;
   logic [CNT_W-1:0] snap;

   assign hold_w = inh_st.hold;
   assign low_w  = inh_st.low_done;

   pl_inhibit_ctrl u_inh (
      .clk      (clk),
      .rst_n    (rst_n),
      .oe_n     (oe_n),
      .byte_sel (byte_sel),
      .st       (inh_st)
   );

   pl_snapshot_reg #(.W(CNT_W)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold_w),
      .cnt   (count_i),
      .snap  (snap)
   );

   pl_byte_mux #(.W(CNT_W)) u_mux (
      .oe_n     (oe_n),
      .byte_sel (byte_sel),
      .snap     (snap),
      .data_o   (data_o),
      .data_oe  (data_oe)
   );
endmodule

// File: rtl/pl_latch_checker.sv
module pl_latch_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             oe_n,
   input logic             byte_sel,
   input logic [7:0]       data_o,
   input logic             data_oe,
   input logic             hold,
   input logic             low_done,
   input logic [CNT_W-1:0] snap
);
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> snap == $past(count_i));

   assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> snap == $past(snap));

   assert_set_inhibit_R6: assert property (@(negedge clk) disable iff (!rst_n)
      !oe_n |=> hold);

   assert_keep_until_low_R7: assert property (@(negedge clk) disable iff (!rst_n)
      (hold && !low_done) |=> hold);

   assert_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!data_oe && data_o == 8'h00));

   assert_sel_no_effect_on_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $stable(oe_n) && $changed(byte_sel)) |-> $stable(snap));
endmodule

bind pos_latch_bytebus pl_latch_checker #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_i  (count_i),
   .oe_n     (oe_n),
   .byte_sel (byte_sel),
   .data_o   (data_o),
   .data_oe  (data_oe),
   .hold     (hold_w),
   .low_done (low_w),
   .snap     (snap)
);

// File: tb/pos_latch_bytebus_tb_top.sv
`timescale 1ns/1ps
module pos_latch_bytebus_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt = 16'h1234;
   logic        oe_n = 1'b1;
   logic        sel = 1'b0;
   logic [7:0]  data16, data12;
   logic        oe16, oe12;
   int          nchk = 0;
   int          nfail = 0;

   always #10 clk = ~clk;

   pos_latch_bytebus #(.CNT_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .count_i(cnt), .oe_n(oe_n),
      .byte_sel(sel), .data_o(data16), .data_oe(oe16));

   pos_latch_bytebus #(.CNT_W(12)) dut12_i (
      .clk(clk), .rst_n(rst_n), .count_i(cnt[11:0]), .oe_n(oe_n),
      .byte_sel(sel), .data_o(data12), .data_oe(oe12));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // Full two-byte read of the expected 16-bit snapshot; also checks the 12-bit copy.
   task automatic read_pair(input logic [15:0] exp, input string tag);
      oe_n = 1'b0; sel = 1'b0; #1;
      chk(data16 == exp[15:8], {tag, " R3 high byte"}, data16, exp[15:8]);
      chk(data12 == {4'h0, exp[11:8]}, {tag, " R4 12-bit high byte"}, data12, {4'h0, exp[11:8]});
      step();
      sel = 1'b1; #1;
      chk(data16 == exp[7:0], {tag, " R3 low byte"}, data16, exp[7:0]);
      chk(data12 == exp[7:0], {tag, " R4 12-bit low byte"}, data12, exp[7:0]);
      step();
      oe_n = 1'b1; sel = 1'b0;
      step();
      step();
   endtask

   task automatic t_reset();
      oe_n = 1'b0; sel = 1'b0; #5;
      chk(data16 == 8'h00 && oe16, "R1 high byte in reset", data16, 0);
      sel = 1'b1; #1;
      chk(data16 == 8'h00, "R1 low byte in reset", data16, 0);
      oe_n = 1'b1; sel = 1'b0;
      step();
      rst_n = 1'b1;
      cnt = 16'hBEEF;
      step();
   endtask

   task automatic t_hiz();
      oe_n = 1'b1; sel = 1'b0; #1;
      chk(!oe16 && data16 == 8'h00, "R5 idle sel=0", data16, 0);
      sel = 1'b1; #1;
      chk(!oe16 && data16 == 8'h00, "R5 idle sel=1", data16, 0);
      chk(!oe12 && data12 == 8'h00, "R5 idle 12-bit", data12, 0);
      sel = 1'b0;
   endtask

   task automatic t_track();
      read_pair(16'hBEEF, "R2 first load");
      cnt = 16'hA55A; step();
      cnt = 16'h0F3C; step();
      read_pair(16'h0F3C, "R2 latest count");
      cnt = 16'hFFFF; step();
      read_pair(16'hFFFF, "R2 all ones");
   endtask

   task automatic t_coherent();
      cnt = 16'h12FF; step();
      oe_n = 1'b0; sel = 1'b0; cnt = 16'h1300; #1;
      chk(data16 == 8'h12, "R6 high byte of snapshot", data16, 8'h12);
      step();
      sel = 1'b1; cnt = 16'h1301; #1;
      chk(data16 == 8'hFF, "R6 low byte same snapshot", data16, 8'hFF);
      step();
      oe_n = 1'b1; sel = 1'b0; cnt = 16'h1302;
      @(negedge clk); #2;
      // Freeze is now clear but no rising edge has passed: still old value.
      oe_n = 1'b0; sel = 1'b1; #1;
      chk(data16 == 8'hFF, "R8 no reload before rising edge", data16, 8'hFF);
      @(posedge clk); #1;
      chk(data16 == 8'h02, "R8 reload on first rising edge", data16, 8'h02);
      #1;
      step();
      oe_n = 1'b1; sel = 1'b0;
      step();
      step();
      read_pair(16'h1302, "R8 settled");
   endtask

   task automatic t_high_only();
      cnt = 16'h4444; step();
      oe_n = 1'b0; sel = 1'b0; #1;
      chk(data16 == 8'h44, "R7 high-only read", data16, 8'h44);
      step();
      oe_n = 1'b1; cnt = 16'h5555;
      step(); step(); step();
      read_pair(16'h4444, "R7 still frozen");
      read_pair(16'h5555, "R7 released after low read");
   endtask

   initial begin
      t_reset();
      t_hiz();
      t_track();
      t_coherent();
      t_high_only();
      t_hiz();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #200000;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule